// File: doc/BRIEF.md
# Longest Prefix Match Engine

This block resolves a 32-bit IPv4 destination address to an outgoing port. It keeps a small forwarding table of rules, each holding a prefix value, a prefix length and a port number. Every valid rule is compared against the address at the same time. Among the rules that match, the one with the greatest prefix length wins, and its port is returned. If no rule matches, the block reports a miss.

Table updates use a write port that is separate from the lookup port. Software or a control engine writes one rule per cycle, selecting the entry by index. The lookup path is a two-stage pipeline. The first stage finds the matching rules. The second stage picks the longest one. A new address may enter on every cycle, and each lookup returns its result two cycles after it enters.

Top module: `lpm_engine`

## Requirements
- R1: After reset, every table entry is invalid and res_valid is 0, so a lookup made before any write reports a miss.
- R2: An address matches a valid rule when its leading bits equal the rule's leading prefix bits, for as many bits as the rule's length. Prefix bits below that length are ignored, both when the rule is written and when it is compared.
- R3: When several rules match, the result comes from the rule with the largest length.
- R4: When the longest matching length is shared by more than one rule, the rule with the lowest entry index wins.
- R5: On a miss (no valid rule matches), res_hit is 0 and res_port and res_len are both 0.
- R6: A rule of length 0 matches every address and so acts as a default route. A length written above 32 is stored and treated as 32.
- R7: A lookup presented with lk_valid high at a clock edge produces res_valid high exactly two edges later. The block accepts one lookup on every cycle.
- R8: A rule write is seen by lookups presented on the cycle after the write. A lookup presented in the same cycle as the write sees the previous table contents.
- R9: Writing an entry with wr_valid at 0 removes that entry from all later matching.
- R10: On a hit, res_port is the winning rule's port and res_len is its stored length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | 5 | Index of the entry to write |
| wr_valid | input | 1 | Valid bit for the written entry (0 removes it) |
| wr_prefix | input | 32 | Prefix value; bits below the length are ignored |
| wr_len | input | 6 | Prefix length, 0 to 32; larger values are saturated to 32 |
| wr_port | input | 4 | Outgoing port for the entry |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | The result belongs to a lookup made two cycles earlier |
| res_hit | output | 1 | At least one valid rule matched |
| res_port | output | 4 | Port of the winning rule, 0 on a miss |
| res_len | output | 6 | Length of the winning rule, 0 on a miss |

## Verification
The assertions assume that rst_n is held low for at least one edge before any traffic, and that lk_valid is a clean level sampled on each edge, with no constraint on how often it is asserted. The bench holds lk_valid low during reset. It drives lookups both one at a time and back to back, so the two-edge relation between lk_valid and res_valid is exercised when the pipeline is idle and when it is full. Rule writes are made on chosen cycles: alone, or in the same cycle as a lookup. This lets the write-visibility ordering be observed directly at the result port.

// File: rtl/lpm_pkg.sv
// Package: shared widths and the stored rule record for the prefix engine.
// Assumes IPv4 addresses and a table depth that is a power of two.
package lpm_pkg;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 6;
    localparam int PORT_W  = 4;
    localparam int ENTRIES = 32;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] prefix;  // stored already masked
        logic [LEN_W-1:0]  len;     // saturated to ADDR_W
        logic [PORT_W-1:0] port;
    } rule_t;

    // Mask with the top 'len' bits set; len >= ADDR_W gives all ones.
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] ones;
        ones = '1;
        if (int'(len) >= ADDR_W) return ones;
        return ~(ones >> len);
    endfunction
endpackage

// File: rtl/lpm_table.sv
// Module: rule storage. Writes one entry per cycle by index; the prefix is
// masked and the length saturated on the way in, so the lookup path only
// compares. Assumes wr_idx addresses an existing entry.
module lpm_table
    import lpm_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [PORT_W-1:0] wr_port,
    output rule_t [N-1:0]     rules_o
);
    logic [LEN_W-1:0] len_sat;

    // Saturate out-of-range lengths to a full-width prefix.
    always_comb begin
        len_sat = (int'(wr_len) > ADDR_W) ? LEN_W'(ADDR_W) : wr_len;
    end

    // Entry registers: clear on reset, load the indexed entry on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rules_o <= '0;
        end else if (wr_en) begin
            rules_o[wr_idx].valid  <= wr_valid;
            rules_o[wr_idx].prefix <= wr_prefix & len_mask(len_sat);
            rules_o[wr_idx].len    <= len_sat;
            rules_o[wr_idx].port   <= wr_port;
        end
    end
endmodule

// File: rtl/lpm_match.sv
// Module: pipeline stage one. Compares the address against every rule in
// parallel and registers the per-entry hit flags along with a snapshot of the
// lengths and ports, so that a later write cannot change a lookup in flight.
module lpm_match
    import lpm_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rule_t [N-1:0]     rules_i,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              s1_valid,
    output logic [N-1:0]      s1_hit,
    output logic [N-1:0][LEN_W-1:0]  s1_len,
    output logic [N-1:0][PORT_W-1:0] s1_port
);
    logic [N-1:0] hit_c;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Entry g matches when it is valid and the masked address equals its prefix.
        always_comb begin
            hit_c[g] = rules_i[g].valid &&
                       ((lk_addr & len_mask(rules_i[g].len)) == rules_i[g].prefix);
        end
    end

    // Stage-one registers: valid flag, hit vector, length and port snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= '0;
            s1_len   <= '0;
            s1_port  <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_hit   <= lk_valid ? hit_c : '0;
            for (int i = 0; i < N; i++) begin
                s1_len[i]  <= rules_i[i].len;
                s1_port[i] <= rules_i[i].port;
            end
        end
    end
endmodule

// File: rtl/lpm_select.sv
// Module: pipeline stage two. Picks the hit with the greatest length, the
// lowest index winning a tie, and registers port, length and hit flag.
// A miss yields zero port and length.
module lpm_select
    import lpm_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [N-1:0]      s1_hit,
    input  logic [N-1:0][LEN_W-1:0]  s1_len,
    input  logic [N-1:0][PORT_W-1:0] s1_port,
    output logic              res_valid,
    output logic              res_hit,
    output logic [PORT_W-1:0] res_port,
    output logic [LEN_W-1:0]  res_len
);
    logic              best_hit;
    logic [LEN_W-1:0]  best_len;
    logic [PORT_W-1:0] best_port;

    // Scan from the highest index down; ">=" lets lower indices take ties.
    always_comb begin
        best_hit  = 1'b0;
        best_len  = '0;
        best_port = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (s1_hit[i] && (!best_hit || s1_len[i] >= best_len)) begin
                best_hit  = 1'b1;
                best_len  = s1_len[i];
                best_port = s1_port[i];
            end
        end
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_port  <= '0;
            res_len   <= '0;
        end else begin
            res_valid <= s1_valid;
            res_hit   <= best_hit;
            res_port  <= best_port;
            res_len   <= best_len;
        end
    end
endmodule

// File: rtl/lpm_engine.sv
// Module: top of the longest-prefix lookup engine. Table storage, a parallel
// match stage and a longest-length select stage; two-cycle lookup latency,
// one lookup accepted per cycle. Assumes synchronous active-low reset.
module lpm_engine
    import lpm_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [PORT_W-1:0] res_port,
    output logic [LEN_W-1:0]  res_len
);
    rule_t [N-1:0]             rules;
    logic                      s1_valid;
    logic [N-1:0]              s1_hit;
    logic [N-1:0][LEN_W-1:0]   s1_len;
    logic [N-1:0][PORT_W-1:0]  s1_port;

    lpm_table #(.N(N)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_prefix(wr_prefix), .wr_len(wr_len),
        .wr_port(wr_port), .rules_o(rules)
    );

    lpm_match #(.N(N)) u_match (
        .clk(clk), .rst_n(rst_n), .rules_i(rules), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .s1_valid(s1_valid), .s1_hit(s1_hit),
        .s1_len(s1_len), .s1_port(s1_port)
    );

    lpm_select #(.N(N)) u_select (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_hit(s1_hit),
        .s1_len(s1_len), .s1_port(s1_port), .res_valid(res_valid),
        .res_hit(res_hit), .res_port(res_port), .res_len(res_len)
    );
endmodule

// File: rtl/lpm_engine_chk.sv
// Checker: port-level properties of the lookup engine, bound to every instance.
module lpm_engine_chk
    import lpm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic [PORT_W-1:0] res_port,
    input logic [LEN_W-1:0]  res_len
);
    // R7: each accepted lookup yields a result two edges later.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ##2 res_valid);

    // R7: no result appears without a lookup two edges before it.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ##2 !res_valid);

    // R5: a miss carries zero port and length.
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_port == '0 && res_len == '0));

    // R10: a hit only accompanies a valid result.
    a_r10_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R6: the reported length never exceeds the address width.
    a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(res_len) <= ADDR_W);
endmodule

bind lpm_engine lpm_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
    .res_hit(res_hit), .res_port(res_port), .res_len(res_len)
);

// File: tb/lpm_engine_tb.sv
module lpm_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_prefix = '0;
    logic [5:0]  wr_len = '0;
    logic [3:0]  wr_port = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_hit;
    logic [3:0]  res_port;
    logic [5:0]  res_len;

    int total = 0;
    int bad = 0;

    // Reference table, kept from the requirements.
    logic        m_valid [32];
    logic [31:0] m_pfx   [32];
    logic [5:0]  m_len   [32];
    logic [3:0]  m_port  [32];

    lpm_engine u_dut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] mk_mask(input int l);
        if (l >= 32) return 32'hFFFF_FFFF;
        if (l == 0) return 32'h0;
        return ~(32'hFFFF_FFFF >> l);
    endfunction

    // Expected result: longest match, lowest index on tie; miss gives zeros.
    task automatic expect_for(input logic [31:0] a, output logic h,
                              output logic [3:0] p, output logic [5:0] l);
        h = 0; p = 0; l = 0;
        for (int i = 0; i < 32; i++) begin
            if (m_valid[i] && ((a & mk_mask(m_len[i])) == (m_pfx[i] & mk_mask(m_len[i])))) begin
                if (!h || m_len[i] > l) begin
                    h = 1; p = m_port[i]; l = m_len[i];
                end
            end
        end
    endtask

    task automatic check(input string req, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_res(input string req, input logic [31:0] a,
                             input logic eh, input logic [3:0] ep, input logic [5:0] el);
        check(req, res_valid == 1'b1, "valid", 32'(res_valid), 32'd1);
        check(req, res_hit == eh, "hit", 32'(res_hit), 32'(eh));
        check(req, res_port == ep, "port", 32'(res_port), 32'(ep));
        check(req, res_len == el, "len", 32'(res_len), 32'(el));
    endtask

    // Drive a write at a negedge and update the model.
    task automatic wr(input int idx, input logic v, input logic [31:0] pf,
                      input int len, input int port);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'(idx); wr_valid = v; wr_prefix = pf;
        wr_len = 6'(len); wr_port = 4'(port);
        @(negedge clk);
        wr_en = 0;
        m_valid[idx] = v; m_pfx[idx] = pf;
        m_len[idx] = (len > 32) ? 6'd32 : 6'(len); m_port[idx] = 4'(port);
    endtask

    // Single lookup; result checked two edges after it is sampled.
    task automatic lookup(input string req, input logic [31:0] a);
        logic eh; logic [3:0] ep; logic [5:0] el;
        expect_for(a, eh, ep, el);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0;
        @(negedge clk);
        check_res(req, a, eh, ep, el);
    endtask

    task automatic t_reset;
        check("R1", res_valid == 0, "res_valid after reset", 32'(res_valid), 0);
        lookup("R1", 32'hC0A8_0101);
    endtask

    task automatic t_basic;
        wr(0, 1, 32'h0A00_0000, 8, 3);
        lookup("R2", 32'h0A12_3456);
        lookup("R5", 32'h0B00_0000);
        wr(1, 1, 32'hC0A8_01FF, 24, 5);       // low bits set but ignored
        lookup("R2", 32'hC0A8_0177);
        lookup("R10", 32'hC0A8_0100);
    endtask

    task automatic t_longest;
        wr(2, 1, 32'h0A01_0000, 16, 7);
        wr(3, 1, 32'h0A01_0200, 24, 9);
        lookup("R3", 32'h0A01_0205);
        lookup("R3", 32'h0A01_0305);
        lookup("R3", 32'h0A05_0000);
    endtask

    task automatic t_tie;
        wr(6, 1, 32'h0A01_0000, 16, 12);     // same length as entry 2, higher index
        lookup("R4", 32'h0A01_0900);
        wr(2, 0, 32'h0, 0, 0);                // R9: remove entry 2
        lookup("R9", 32'h0A01_0900);
    endtask

    task automatic t_default_sat;
        wr(10, 1, 32'hDEAD_BEEF, 0, 1);
        lookup("R6", 32'h1234_5678);
        wr(11, 1, 32'h1234_5678, 45, 14);
        lookup("R6", 32'h1234_5678);
        lookup("R6", 32'h1234_5679);
        wr(10, 0, 32'h0, 0, 0);
    endtask

    task automatic t_write_order;
        logic eh; logic [3:0] ep; logic [5:0] el;
        // Same-cycle write and lookup: the lookup sees the old table.
        expect_for(32'h2000_0001, eh, ep, el);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd20; wr_valid = 1; wr_prefix = 32'h2000_0000;
        wr_len = 6'd8; wr_port = 4'd6;
        lk_valid = 1; lk_addr = 32'h2000_0001;
        @(negedge clk);
        wr_en = 0;
        m_valid[20] = 1; m_pfx[20] = 32'h2000_0000; m_len[20] = 8; m_port[20] = 6;
        // Next cycle: new rule is visible.
        lk_addr = 32'h2000_0001;
        @(negedge clk);
        lk_valid = 0;
        check_res("R8", 32'h2000_0001, eh, ep, el);
        @(negedge clk);
        check_res("R8", 32'h2000_0001, 1'b1, 4'd6, 6'd8);
    endtask

    task automatic t_stream;
        logic [31:0] addrs [6];
        logic eh [6]; logic [3:0] ep [6]; logic [5:0] el [6];
        addrs[0] = 32'h0A01_0205; addrs[1] = 32'h0B00_0000; addrs[2] = 32'hC0A8_0101;
        addrs[3] = 32'h1234_5678; addrs[4] = 32'h2000_00FF; addrs[5] = 32'h0A01_0900;
        for (int i = 0; i < 6; i++) expect_for(addrs[i], eh[i], ep[i], el[i]);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k >= 2) check_res("R7", addrs[k-2], eh[k-2], ep[k-2], el[k-2]);
            if (k < 6) begin lk_valid = 1; lk_addr = addrs[k]; end
            else lk_valid = 0;
        end
        @(negedge clk);
        check("R7", res_valid == 0, "idle after stream", 32'(res_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_valid[i] = 0; m_pfx[i] = 0; m_len[i] = 0; m_port[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_longest();
        t_tie();
        t_default_sat();
        t_write_order();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule